// File: doc/BRIEF.md
# Compressed Stack Capability Adder

This block executes the two 16-bit compressed instructions that add an immediate to the stack-pointer capability of a 64-bit capability core. The first, the frame-adjust form, moves the stack pointer by a signed multiple of 16 and writes the result back to register 2. The second, the slot-address form, adds an unsigned multiple of 4 to the stack pointer and writes the result to one of the eight compressed-range registers, x8 to x15. The caller presents the instruction word together with the stack-pointer capability, already split into its tag, sealed flag, reserved bits, malformed-bounds flag, address and decoded bounds.

One cycle after a valid input, the block returns the destination index, the new address and the new tag. The bounds, sealed flag, reserved bits and malformed flag pass through unchanged. The tag survives only when several conditions all hold: the source is tagged, unsealed and well formed, with clean reserved bits, and the new address stays inside a window of `WIN` bytes below the base and above the top. All address arithmetic wraps modulo 2^64. Words that match neither form, and either form with an all-zero immediate, are flagged as illegal.

Top module: `cap_sp_adder`

## Requirements
- R1: Frame-adjust form (instr[1:0]=01, instr[15:13]=011, instr[11:7]=2, immediate nonzero). The signed offset is built from instr[12] into bit 9, instr[4:3] into bits 8:7, instr[5] into bit 6, instr[2] into bit 5 and instr[6] into bit 4, with bits 3:0 zero, then sign-extended. This gives multiples of 16 from -512 to 496. The new address is the source address plus this offset, and outRd is 2.
- R2: Slot-address form (instr[1:0]=00, instr[15:13]=000, instr[12:5] nonzero). The unsigned offset takes instr[12:11] into bits 5:4, instr[10:7] into bits 9:6, instr[6] into bit 2 and instr[5] into bit 3, with bits 1:0 zero. The new address is the source address plus this offset, and outRd is 8 + instr[4:2].
- R3: Either form with a zero immediate, and any word matching neither form, sets outIllegal=1 and outTag=0, and returns the source address unchanged.
- R4: A sealed source capability gives outTag=0.
- R5: A source with the malformed-bounds flag set, or with any reserved bit set, gives outTag=0.
- R6: The tag is kept only if the new address lies in the circular range from base-WIN to top+WIN, both ends included. Otherwise outTag=0.
- R7: Address addition and the window test wrap modulo 2^64.
- R8: outBase, outTop, outSealed, outReserved and outMalformed equal the source values sampled with the instruction.
- R9: Outputs are registered. outValid is high exactly one cycle after inValid. During reset outValid=0 and outTag=0.
- R10: An untagged source never produces outTag=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and source are valid |
| instr | input | 16 | Compressed instruction word |
| srcTag | input | 1 | Source capability tag |
| srcSealed | input | 1 | Source is sealed |
| srcReserved | input | RSV_W | Source reserved-field bits |
| srcMalformed | input | 1 | Source bounds decode as malformed |
| srcAddr | input | ADDR_W | Source address |
| srcBase | input | ADDR_W | Decoded base |
| srcTop | input | ADDR_W | Decoded top |
| outValid | output | 1 | Result valid |
| outIllegal | output | 1 | Word is not a legal form |
| outRd | output | 5 | Destination register index |
| outTag | output | 1 | Result tag |
| outAddr | output | ADDR_W | Result address |
| outSealed | output | 1 | Pass-through sealed flag |
| outReserved | output | RSV_W | Pass-through reserved bits |
| outMalformed | output | 1 | Pass-through malformed flag |
| outBase | output | ADDR_W | Pass-through base |
| outTop | output | ADDR_W | Pass-through top |

## Verification
The bench sweeps every nonzero immediate of both forms, using a narrow window so that both window edges fall inside the sweep. A wrong bit in the immediate scatter would show up there as a shifted address, and an off-by-one in the bound compare would keep or drop the tag at exactly base-WIN or top+WIN. Zero immediates and the neighbouring word that shares the frame-adjust opcode but names another register must raise the illegal flag; a design that misses this would add zero or corrupt the stack pointer. A stack pointer just above address zero that moves below it must wrap and stay tagged, which catches a window test built on non-circular compares.

// File: rtl/cap_sp_pkg.sv
package cap_sp_pkg;
  localparam int REG_W = 5;
  localparam int OFF_W = 10;
  localparam logic [REG_W-1:0] SP_REG = 5'd2;
  localparam logic [1:0] QUAD_SLOT = 2'b00;
  localparam logic [1:0] QUAD_FRAME = 2'b01;
  localparam logic [2:0] F3_SLOT = 3'b000;
  localparam logic [2:0] F3_FRAME = 3'b011;

  typedef struct packed {
    logic useFrame;
    logic useSlot;
    logic illegal;
    logic [REG_W-1:0] rd;
  } ctlStrobes_t;
endpackage

// File: rtl/csa_ctrl.sv
module csa_ctrl
  import cap_sp_pkg::*;
(
  input  logic [15:0]  instr,
  output ctlStrobes_t  ctl
);
  logic [1:0] quad;
  logic [2:0] f3;
  logic slotForm, slotZero, frameForm, frameZero;

  always_comb begin
    quad = instr[1:0];
    f3 = instr[15:13];
    slotForm = (quad == QUAD_SLOT) && (f3 == F3_SLOT);
    slotZero = (instr[12:5] == 8'd0);
    frameForm = (quad == QUAD_FRAME) && (f3 == F3_FRAME) && (instr[11:7] == SP_REG);
    frameZero = ({instr[12], instr[6:2]} == 6'd0);
    ctl.useFrame = frameForm && !frameZero;
    ctl.useSlot = slotForm && !slotZero;
    ctl.illegal = !(ctl.useFrame || ctl.useSlot);
    // compressed register field maps onto x8..x15
    ctl.rd = ctl.useSlot ? {2'b01, instr[4:2]} : SP_REG;
  end
endmodule

// File: rtl/csa_datapath.sv
module csa_datapath
  import cap_sp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int RSV_W = 4,
  parameter int unsigned WIN = 4096
) (
  input  logic [15:0]       instr,
  input  ctlStrobes_t       ctl,
  input  logic              srcTag,
  input  logic              srcSealed,
  input  logic [RSV_W-1:0]  srcReserved,
  input  logic              srcMalformed,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] srcTop,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              nextTag
);
  localparam logic [ADDR_W-1:0] WIN_V = ADDR_W'(WIN);
  localparam logic [ADDR_W-1:0] WIN2_V = ADDR_W'(2 * longint'(WIN));

  logic [OFF_W-1:0] frameOff, slotOff;
  logic [ADDR_W-1:0] offset, sum, rel, span;
  logic inWin, capOk;

  always_comb begin
    frameOff = {instr[12], instr[4:3], instr[5], instr[2], instr[6], 4'b0000};
    slotOff = {instr[10:7], instr[12:11], instr[5], instr[6], 2'b00};
    if (ctl.useFrame)
      offset = {{(ADDR_W-OFF_W){frameOff[OFF_W-1]}}, frameOff};
    else if (ctl.useSlot)
      offset = {{(ADDR_W-OFF_W){1'b0}}, slotOff};
    else
      offset = '0;
    sum = srcAddr + offset;
    // circular interval test: distance above (base-WIN) against widened span
    rel = sum - srcBase + WIN_V;
    span = srcTop - srcBase + WIN2_V;
    inWin = (rel <= span);
    capOk = srcTag && !srcSealed && !srcMalformed && (srcReserved == '0);
    nextTag = capOk && inWin && !ctl.illegal;
    nextAddr = ctl.illegal ? srcAddr : sum;
  end
endmodule

// File: rtl/cap_sp_adder.sv
module cap_sp_adder
  import cap_sp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int RSV_W = 4,
  parameter int unsigned WIN = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [15:0]       instr,
  input  logic              srcTag,
  input  logic              srcSealed,
  input  logic [RSV_W-1:0]  srcReserved,
  input  logic              srcMalformed,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] srcTop,
  output logic              outValid,
  output logic              outIllegal,
  output logic [4:0]        outRd,
  output logic              outTag,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outSealed,
  output logic [RSV_W-1:0]  outReserved,
  output logic              outMalformed,
  output logic [ADDR_W-1:0] outBase,
  output logic [ADDR_W-1:0] outTop
);
  ctlStrobes_t ctl;
  logic [ADDR_W-1:0] nextAddr;
  logic nextTag;

  csa_ctrl uCtrl (.instr(instr), .ctl(ctl));

  csa_datapath #(.ADDR_W(ADDR_W), .RSV_W(RSV_W), .WIN(WIN)) uDp (
    .instr(instr), .ctl(ctl),
    .srcTag(srcTag), .srcSealed(srcSealed), .srcReserved(srcReserved),
    .srcMalformed(srcMalformed), .srcAddr(srcAddr), .srcBase(srcBase),
    .srcTop(srcTop), .nextAddr(nextAddr), .nextTag(nextTag)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outTag <= 1'b0;
      outIllegal <= 1'b0;
      outRd <= '0;
      outAddr <= '0;
      outSealed <= 1'b0;
      outReserved <= '0;
      outMalformed <= 1'b0;
      outBase <= '0;
      outTop <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outTag <= nextTag;
        outIllegal <= ctl.illegal;
        outRd <= ctl.rd;
        outAddr <= nextAddr;
        outSealed <= srcSealed;
        outReserved <= srcReserved;
        outMalformed <= srcMalformed;
        outBase <= srcBase;
        outTop <= srcTop;
      end
    end
  end

  a_r4_sealed_drops_tag: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(srcSealed) |-> !outTag);
  a_r5_malformed_drops_tag: assert property (@(posedge clk) disable iff (!rstN)
    outValid && ($past(srcMalformed) || $past(srcReserved) != '0) |-> !outTag);
  a_r10_no_tag_gain: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(srcTag) |-> !outTag);
  a_r3_illegal_untagged: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIllegal |-> !outTag && outAddr == $past(srcAddr));
  a_r2_slot_rd_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outIllegal && $past(instr[1:0]) == QUAD_SLOT |-> outRd[4:3] == 2'b01);
  a_r1_frame_rd_sp: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outIllegal && $past(instr[1:0]) == QUAD_FRAME |-> outRd == SP_REG);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outValid == $past(inValid));
  a_r8_base_passthru: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outBase == $past(srcBase) && outTop == $past(srcTop));
endmodule

// File: tb/tb_cap_sp_adder.sv
`timescale 1ns/1ps
module tb_cap_sp_adder;
  localparam int AW = 64;
  localparam int RW = 4;
  localparam longint WINB = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] instr = '0;
  logic srcTag = 1'b0, srcSealed = 1'b0, srcMalformed = 1'b0;
  logic [RW-1:0] srcReserved = '0;
  logic [AW-1:0] srcAddr = '0, srcBase = '0, srcTop = '0;
  logic outValid, outIllegal, outTag, outSealed, outMalformed;
  logic [4:0] outRd;
  logic [RW-1:0] outReserved;
  logic [AW-1:0] outAddr, outBase, outTop;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cap_sp_adder #(.ADDR_W(AW), .RSV_W(RW), .WIN(64)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .srcTag(srcTag), .srcSealed(srcSealed), .srcReserved(srcReserved),
    .srcMalformed(srcMalformed), .srcAddr(srcAddr), .srcBase(srcBase),
    .srcTop(srcTop), .outValid(outValid), .outIllegal(outIllegal),
    .outRd(outRd), .outTag(outTag), .outAddr(outAddr), .outSealed(outSealed),
    .outReserved(outReserved), .outMalformed(outMalformed),
    .outBase(outBase), .outTop(outTop)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] encFrame(input int units);
    logic [9:0] o;
    o = 10'(units * 16);
    return {3'b011, o[9], 5'd2, o[4], o[6], o[8:7], o[5], 2'b01};
  endfunction

  function automatic logic [15:0] encSlot(input int units, input int rdp);
    logic [9:0] o;
    logic [2:0] r;
    o = 10'(units * 4);
    r = 3'(rdp);
    return {3'b000, o[5:4], o[9:6], o[2], o[3], r, 2'b00};
  endfunction

  // drive at negedge, result is registered at the next posedge, sample at the following negedge
  task automatic issue(input logic [15:0] w);
    instr = w;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkResult(input string req, input bit expIll, input logic [4:0] expRd,
                             input logic [63:0] expAddr, input bit expTag);
    chk(outValid == 1'b1, "R9", "valid", 64'(outValid), 64'd1);
    chk(outIllegal == expIll, req, "illegal", 64'(outIllegal), 64'(expIll));
    if (!expIll) chk(outRd == expRd, req, "rd", 64'(outRd), 64'(expRd));
    chk(outAddr == expAddr, req, "addr", outAddr, expAddr);
    chk(outTag == expTag, req, "tag", 64'(outTag), 64'(expTag));
  endtask

  function automatic bit inWindow(input longint a, input longint b, input longint t);
    return (a >= b - WINB) && (a <= t + WINB);
  endfunction

  task automatic setCap(input logic [63:0] a, input logic [63:0] b, input logic [63:0] t);
    srcTag = 1'b1; srcSealed = 1'b0; srcMalformed = 1'b0; srcReserved = '0;
    srcAddr = a; srcBase = b; srcTop = t;
  endtask

  initial begin : watchdog
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    longint sp, bs, tp, e;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R9", "reset valid", 64'(outValid), 64'd0);
    chk(outTag == 1'b0, "R9", "reset tag", 64'(outTag), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R9", "idle valid", 64'(outValid), 64'd0);

    sp = 64'h1000; bs = 64'h1000; tp = 64'h1100;
    // R1 frame-adjust sweep over every nonzero immediate, window edges inside
    for (int u = -32; u < 32; u++) begin
      if (u != 0) begin
        setCap(sp, bs, tp);
        issue(encFrame(u));
        e = sp + u * 16;
        checkResult("R1/R6", 1'b0, 5'd2, e, inWindow(e, bs, tp));
        chk(outBase == bs && outTop == tp, "R8", "bounds", outBase, bs);
      end
    end
    // R2 slot-address sweep, two register fields
    for (int r = 0; r < 8; r += 7) begin
      for (int u = 1; u < 256; u++) begin
        setCap(sp, bs, tp);
        issue(encSlot(u, r));
        e = sp + u * 4;
        checkResult("R2/R6", 1'b0, 5'(8 + r), e, inWindow(e, bs, tp));
      end
    end
    // R3 zero immediates and a neighbouring encoding
    setCap(sp, bs, tp);
    issue(encFrame(0));
    checkResult("R3", 1'b1, 5'd0, sp, 1'b0);
    issue(encSlot(0, 3));
    checkResult("R3", 1'b1, 5'd0, sp, 1'b0);
    issue(encFrame(1) ^ 16'h0180);
    checkResult("R3", 1'b1, 5'd0, sp, 1'b0);
    // R4 sealed
    setCap(sp, bs, tp); srcSealed = 1'b1;
    issue(encFrame(1));
    checkResult("R4", 1'b0, 5'd2, sp + 16, 1'b0);
    chk(outSealed == 1'b1, "R8", "sealed pass", 64'(outSealed), 64'd1);
    // R5 malformed and reserved
    setCap(sp, bs, tp); srcMalformed = 1'b1;
    issue(encSlot(2, 1));
    checkResult("R5", 1'b0, 5'd9, sp + 8, 1'b0);
    chk(outMalformed == 1'b1, "R8", "malformed pass", 64'(outMalformed), 64'd1);
    for (int b = 0; b < RW; b++) begin
      setCap(sp, bs, tp); srcReserved = RW'(1) << b;
      issue(encSlot(2, 1));
      checkResult("R5", 1'b0, 5'd9, sp + 8, 1'b0);
      chk(outReserved == (RW'(1) << b), "R8", "reserved pass", 64'(outReserved), 64'(RW'(1) << b));
    end
    // R10 untagged stays untagged
    setCap(sp, bs, tp); srcTag = 1'b0;
    issue(encFrame(1));
    checkResult("R10", 1'b0, 5'd2, sp + 16, 1'b0);
    // R7 wrap below zero, still within circular window
    setCap(64'h10, 64'h0, 64'h100);
    issue(encFrame(-2));
    checkResult("R7", 1'b0, 5'd2, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1);
    issue(encFrame(-32));
    checkResult("R7", 1'b0, 5'd2, 64'hFFFF_FFFF_FFFF_FE10, 1'b0);
    // R9 valid drops the cycle after inValid falls
    @(negedge clk);
    chk(outValid == 1'b0, "R9", "valid low", 64'(outValid), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule